// File: doc/BRIEF.md
# Sequential-Address Bus Codec with Optional Invert Fallback

This block cuts switching activity on a wide address bus whose traffic is dominated by consecutive addresses. On every accepted address the encoder checks whether the new value equals the previously accepted address plus a fixed stride. If it does, the bus lines are left exactly as they are and a redundant "increment" line is raised. If it does not, the new address is placed on the bus and the increment line is lowered. A run of consecutive addresses therefore costs no bus-line transitions after the first one.

A second redundant "invert" line can be enabled with a mode input. In that mode, a non-consecutive address is compared against the value currently on the bus lines. If more than half of the lines would toggle, the complement of the address is driven and the invert line is raised. A matching decoder sits on the far side. It rebuilds the original address stream from the bus lines and the two side lines. The stride and the mode are configuration inputs, and they are captured once after every reset.

Top module: `seqaddr_codec`

## Requirements
- R1: While reset is asserted and right after it, `bus_o` is all zeros, `inc_o`, `inv_o`, `bus_valid_o` and `dec_valid_o` are 0, and `dec_addr_o` is 0.
- R2: The first address accepted after reset is always driven unmodified on `bus_o` with `inc_o`=0 and `inv_o`=0, even if it equals zero plus the stride.
- R3: An accepted address equal to the previously accepted address plus the stride leaves `bus_o` unchanged and sets `inc_o`=1 and `inv_o`=0.
- R4: With the invert mode off, a non-consecutive address is driven unmodified on `bus_o` with `inc_o`=0 and `inv_o`=0.
- R5: With the invert mode on, a non-consecutive address is compared bitwise with the current `bus_o`. If more than ADDR_W/2 lines differ, `bus_o` takes the bitwise complement of the address and `inv_o`=1. Otherwise `bus_o` takes the address and `inv_o`=0. `inv_o` is never 1 while `inc_o` is 1.
- R6: An address accepted at a clock edge appears on the bus outputs at that edge, with `bus_valid_o`=1 for one cycle per accepted address.
- R7: A cycle with `addr_valid_i`=0 leaves `bus_o`, `inc_o` and `inv_o` unchanged and gives `bus_valid_o`=0. The last accepted address stays the reference for the next consecutive check.
- R8: One clock after each `bus_valid_o` pulse, `dec_valid_o` is 1 and `dec_addr_o` equals the original address.
- R9: Address arithmetic wraps modulo 2^ADDR_W, so the all-ones address followed by (stride − 1) counts as consecutive.
- R10: The stride and the invert mode are taken from the configuration inputs on the first clock after reset release. Later changes to those inputs have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stride_i | input | ADDR_W | Stride between consecutive addresses |
| cfg_invert_en_i | input | 1 | 1 enables the invert fallback for jumps |
| addr_valid_i | input | 1 | Qualifies `addr_i` |
| addr_i | input | ADDR_W | Source address |
| bus_o | output | ADDR_W | Encoded bus lines |
| inc_o | output | 1 | Consecutive-address line |
| inv_o | output | 1 | Inverted-payload line |
| bus_valid_o | output | 1 | Bus carries a new transfer |
| dec_valid_o | output | 1 | Decoded address is valid |
| dec_addr_o | output | ADDR_W | Decoded address |

## Verification
The bench targets the following corner cases:
- **First address after reset equals the stride.** A design that trusts its reset-time reference would freeze the bus instead of sending the value.
- **Jump to the complement of the current bus lines.** This leaves the lines untouched with the invert line raised, which catches a codec that compares against the previous source address rather than the physical bus.
- **Jump that toggles exactly half the lines.** This must not invert; an off-by-one threshold flips it.
- **Wrap past the all-ones address.** A design without modular compare breaks the run here.
- **Idle gaps and a stride change after capture.** These expose designs that drop the reference or follow the live configuration; either one corrupts the decoded stream.

// File: rtl/seqcodec_pkg.sv
package seqcodec_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_SEQ   = 2'd1,
    KIND_FLIP  = 2'd2
  } xfer_kind_e;
endpackage

// File: rtl/seqcodec_cfg.sv
module seqcodec_cfg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              invert_en_i,
  output logic [ADDR_W-1:0] stride_o,
  output logic              invert_en_o
);
  logic              done_q;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic              inv_q, inv_d;

  always_comb begin
    stride_d = stride_q;
    inv_d    = inv_q;
    if (!done_q) begin
      stride_d = stride_i;
      inv_d    = invert_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      stride_q <= '0;
      inv_q    <= 1'b0;
    end else begin
      done_q   <= 1'b1;
      stride_q <= stride_d;
      inv_q    <= inv_d;
    end
  end

  // First cycle after release uses the live inputs, later the captured copy.
  assign stride_o    = done_q ? stride_q : stride_i;
  assign invert_en_o = done_q ? inv_q    : invert_en_i;

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> ($stable(stride_o) && $stable(invert_en_o)));
endmodule

// File: rtl/seqcodec_enc.sv
module seqcodec_enc
  import seqcodec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              invert_en_i,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  output logic [ADDR_W-1:0] bus_o,
  output logic              inc_o,
  output logic              inv_o,
  output logic              bvalid_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam int HALF  = ADDR_W / 2;

  function automatic logic [CNT_W-1:0] ones(input logic [ADDR_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < ADDR_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  logic [ADDR_W-1:0] prev_q, prev_d, bus_q, bus_d, expect_next;
  logic              have_q, have_d, inc_q, inc_d, inv_q, inv_d, bv_q, bv_d;
  logic [CNT_W-1:0]  flips;
  xfer_kind_e        kind;

  always_comb begin
    expect_next = prev_q + stride_i;
    flips       = ones(in_addr_i ^ bus_q);
    if (have_q && (in_addr_i == expect_next))
      kind = KIND_SEQ;
    else if (invert_en_i && have_q && (flips > CNT_W'(HALF)))
      kind = KIND_FLIP;
    else
      kind = KIND_PLAIN;
  end

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    bus_d  = bus_q;
    inc_d  = inc_q;
    inv_d  = inv_q;
    bv_d   = 1'b0;
    if (in_valid_i) begin
      prev_d = in_addr_i;
      have_d = 1'b1;
      bv_d   = 1'b1;
      unique case (kind)
        KIND_SEQ:  begin inc_d = 1'b1; inv_d = 1'b0; end
        KIND_FLIP: begin bus_d = ~in_addr_i; inc_d = 1'b0; inv_d = 1'b1; end
        default:   begin bus_d = in_addr_i;  inc_d = 1'b0; inv_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
      bus_q  <= '0;
      inc_q  <= 1'b0;
      inv_q  <= 1'b0;
      bv_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
      bus_q  <= bus_d;
      inc_q  <= inc_d;
      inv_q  <= inv_d;
      bv_q   <= bv_d;
    end
  end

  assign bus_o    = bus_q;
  assign inc_o    = inc_q;
  assign inv_o    = inv_q;
  assign bvalid_o = bv_q;

  p_first_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !have_q) |=> (!inc_q && !inv_q && bus_q == $past(in_addr_i)));
  p_seq_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bv_q && inc_q) |-> (bus_q == $past(bus_q)));
  p_inc_no_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_q |-> !inv_q);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(bus_q) && $stable(inc_q) && $stable(inv_q) && !bv_q));
endmodule

// File: rtl/seqcodec_dec.sv
module seqcodec_dec #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              bvalid_i,
  input  logic [ADDR_W-1:0] bus_i,
  input  logic              inc_i,
  input  logic              inv_i,
  output logic              dvalid_o,
  output logic [ADDR_W-1:0] daddr_o
);
  logic [ADDR_W-1:0] last_q, last_d;
  logic              dv_q;

  always_comb begin
    last_d = last_q;
    if (bvalid_i) begin
      if (inc_i)      last_d = last_q + stride_i;
      else if (inv_i) last_d = ~bus_i;
      else            last_d = bus_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      last_q <= last_d;
      dv_q   <= bvalid_i;
    end
  end

  assign dvalid_o = dv_q;
  assign daddr_o  = last_q;

  p_dec_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid_i |=> dv_q);
  p_dec_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_i && !inc_i && !inv_i) |=> (last_q == $past(bus_i)));
  p_dec_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_i && !inc_i && inv_i) |=> (last_q == ~$past(bus_i)));
endmodule

// File: rtl/seqaddr_codec.sv
module seqaddr_codec #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_stride_i,
  input  logic              cfg_invert_en_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] bus_o,
  output logic              inc_o,
  output logic              inv_o,
  output logic              bus_valid_o,
  output logic              dec_valid_o,
  output logic [ADDR_W-1:0] dec_addr_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] stride;
  logic              inv_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  seqcodec_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n),
    .stride_i(cfg_stride_i), .invert_en_i(cfg_invert_en_i),
    .stride_o(stride), .invert_en_o(inv_en)
  );

  seqcodec_enc #(.ADDR_W(ADDR_W)) u_enc (
    .clk(clk), .rst_n(rst_int_n),
    .stride_i(stride), .invert_en_i(inv_en),
    .in_valid_i(addr_valid_i), .in_addr_i(addr_i),
    .bus_o(bus_o), .inc_o(inc_o), .inv_o(inv_o), .bvalid_o(bus_valid_o)
  );

  seqcodec_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .stride_i(stride),
    .bvalid_i(bus_valid_o), .bus_i(bus_o), .inc_i(inc_o), .inv_i(inv_o),
    .dvalid_o(dec_valid_o), .daddr_o(dec_addr_o)
  );
endmodule

// File: tb/tb_seqaddr_codec.sv
`timescale 1ns/1ps
module tb_seqaddr_codec;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cfg_stride;
  logic         cfg_inv;
  logic         avalid;
  logic [W-1:0] addr;
  logic [W-1:0] bus_o, dec_addr_o;
  logic         inc_o, inv_o, bus_valid_o, dec_valid_o;

  int checks = 0, fails = 0;

  logic [W+1:0] enc_q[$];
  logic [W-1:0] dec_q[$];

  logic [W-1:0] m_prev, m_bus, m_stride;
  logic         m_have, m_bi;

  always #5 clk = ~clk;

  seqaddr_codec #(.ADDR_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_stride_i(cfg_stride), .cfg_invert_en_i(cfg_inv),
    .addr_valid_i(avalid), .addr_i(addr), .bus_o(bus_o), .inc_o(inc_o), .inv_o(inv_o),
    .bus_valid_o(bus_valid_o), .dec_valid_o(dec_valid_o), .dec_addr_o(dec_addr_o)
  );

  function automatic int pop(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: computes the expected encoding from R2..R5 and R9.
  task automatic send(input logic [W-1:0] a);
    logic [W-1:0] nxt;
    logic [W-1:0] b;
    logic         ic, iv;
    nxt = m_prev + m_stride;
    @(negedge clk);
    avalid = 1'b1;
    addr   = a;
    if (m_have && a == nxt) begin
      b = m_bus; ic = 1'b1; iv = 1'b0;
    end else if (m_bi && m_have && pop(a ^ m_bus) > W/2) begin
      b = ~a; ic = 1'b0; iv = 1'b1;
    end else begin
      b = a; ic = 1'b0; iv = 1'b0;
    end
    m_bus = b; m_prev = a; m_have = 1'b1;
    enc_q.push_back({b, ic, iv});
    dec_q.push_back(a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      avalid = 1'b0;
    end
  endtask

  task automatic do_reset(input logic [W-1:0] s, input logic bi);
    @(negedge clk);
    rst_n = 1'b0; avalid = 1'b0; cfg_stride = s; cfg_inv = bi;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bus_o == '0 && !inc_o && !inv_o && !bus_valid_o && !dec_valid_o && dec_addr_o == '0,
          "R1", {bus_o, inc_o, inv_o}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_o == '0 && !bus_valid_o && !dec_valid_o, "R1", {bus_o, inc_o, inv_o}, '0);
    m_have = 1'b0; m_bus = '0; m_prev = '0; m_stride = s; m_bi = bi;
  endtask

  // Monitor: R6 (bus one cycle after acceptance) and R8 (decoded one cycle later).
  always @(negedge clk) begin
    if (rst_n && bus_valid_o) begin
      if (enc_q.size() == 0) check(1'b0, "R6", {bus_o, inc_o, inv_o}, '0);
      else begin
        logic [W+1:0] e;
        e = enc_q.pop_front();
        check({bus_o, inc_o, inv_o} == e, "R3/R4/R5 encode", {bus_o, inc_o, inv_o}, e);
      end
    end
    if (rst_n && dec_valid_o) begin
      if (dec_q.size() == 0) check(1'b0, "R8", {2'b0, dec_addr_o}, '0);
      else begin
        logic [W-1:0] d;
        d = dec_q.pop_front();
        check(dec_addr_o == d, "R8 decode", {2'b0, dec_addr_o}, {2'b0, d});
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] lf;
    rst_n = 1'b0; avalid = 1'b0; addr = '0; cfg_stride = 16'd1; cfg_inv = 1'b0;
    m_have = 1'b0; m_bus = '0; m_prev = '0; m_stride = 16'd1; m_bi = 1'b0;
    do_reset(16'd1, 1'b0);

    // R2/R3: run 4..8, bus frozen after the first
    for (int a = 4; a <= 8; a++) send(W'(a));
    // R7: idle gap keeps lines and reference
    idle(3);
    check(bus_o == 16'h0004 && inc_o && !bus_valid_o, "R7", {bus_o, inc_o, inv_o}, {16'h0004, 2'b10});
    send(16'd9);
    // R4: jump in plain mode, then R10: live stride change ignored
    send(16'h1234);
    cfg_stride = 16'd4;
    send(16'h1235);
    // R9: wrap past all ones
    send(16'hFFFF);
    send(16'h0000);
    // Mixed stream
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) send(m_prev + m_stride); else send(lf);
    end
    idle(4);
    check(enc_q.size() == 0 && dec_q.size() == 0, "R6/R8 drained", W'(enc_q.size()), '0);

    // Invert mode, stride 3
    do_reset(16'd3, 1'b1);
    send(16'h0003);          // R2: equals 0+stride but sent plain
    send(16'h0006);          // R3
    send(16'hFFF0);          // R5: 14 lines differ -> invert
    send(16'h00F0);          // R5: exactly half differ -> plain
    send(16'h00F3);          // R3
    send(16'hFF0F);          // R5: complement of bus -> lines unchanged, inv
    send(16'hFFFE);
    send(16'h0001);          // R9 wrap with stride 3
    cfg_inv = 1'b0;          // R10: mode change ignored
    send(16'h8000);
    lf = 16'h1D2B;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[1]) send(m_prev + m_stride); else send(lf);
      if (lf[2]) idle(1);
    end
    idle(4);
    check(enc_q.size() == 0 && dec_q.size() == 0, "R6/R8 drained", W'(enc_q.size()), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule